// File: doc/BRIEF.md
# Flash Automatic Write Status Engine

This block models the device side of a flash array: a command decoder on a simple single-cycle bus, an embedded program algorithm, and a whole-array erase. A host unlocks the device with a fixed series of address/data writes. It then sends either a program command followed by a target word, or an erase command. The engine then runs a timed internal operation. While that operation runs, a read at any address returns a status word instead of array contents: a polling bit, a toggle bit and a timeout bit.

Programming can only clear bits. The word left in the array is the old word ANDed with the new data. If the new data asks for any 0 bit to become 1, the algorithm never completes its polling. When the programming time is used up it raises the timeout bit and waits in a stuck state. A reset command then returns it to normal reads. The array is a small register file that comes out of reset fully erased. Program and erase durations are parameters counted in clock cycles.

The decoder states are ST_READ (array reads, idle), ST_UNL1 and ST_UNL2 (first and second unlock writes seen), ST_PGM_ARM (program command seen, waiting for the target), ST_ERS1, ST_ERS2 and ST_ERS3 (erase setup, then the second unlock pair), ST_PGM_RUN (program timer running), ST_ERS_RUN (erase timer running) and ST_TIMEOUT (failed program, stuck). The transitions are as follows:
- ST_READ to ST_UNL1, ST_UNL1 to ST_UNL2, ST_ERS1 to ST_ERS2 and ST_ERS2 to ST_ERS3 each advance on the matching unlock write.
- ST_UNL2 goes to ST_PGM_ARM or ST_ERS1, depending on the command byte.
- ST_PGM_ARM goes to ST_PGM_RUN on an even target address, or back to ST_READ on an odd one.
- ST_ERS3 goes to ST_ERS_RUN on the chip-erase byte.
- ST_PGM_RUN goes to ST_READ, or to ST_TIMEOUT when a 0-to-1 bit was requested.
- ST_ERS_RUN goes to ST_READ.
- ST_TIMEOUT goes to ST_READ on the reset byte.
- Any other write in a waiting state returns the decoder to ST_READ.

Top module: `flashwr_engine`

## Requirements
- R1: After reset every array word reads 16'hFFFF, and the engine is in read mode.
- R2: Four writes start a program. They are low byte 8'hAA at address UNLOCK_A, 8'h55 at UNLOCK_B, 8'hA0 at UNLOCK_A, then the target write (byte address, data). Reads in the PROG_CYCLES cycles after the target write return status. The read sampled one cycle later returns the new word. An array word sits at byte address 2*index.
- R3: A target write to an odd byte address leaves the array unchanged and returns the engine straight to read mode.
- R4: The word stored by a program is the old word AND the written data, so no bit ever goes from 0 to 1 by programming.
- R5: Every bus write, including the reset byte and complete unlock sequences, is ignored while a program or erase is running.
- R6: A status word has all bits 0 except three. Bit 7 is the complement of bit 7 of the target data, and is 0 during erase. Bit 6 is a toggle, returned as 0 on the first read of an operation and inverted on each later read. Bit 5 is the timeout flag.
- R7: If the data asks for any stored 0 to become 1, the status at the end of the program time shows bit 5 = 1. On that same read bit 7 still shows the complement and bit 6 stops changing. This stays until a reset command.
- R8: A write with low byte 8'hF0 while the engine is in the timeout state clears the timeout and returns it to read mode. Any other write leaves it in the timeout state. Afterwards the failing bits read as 0.
- R9: A write that breaks the unlock sequence returns the decoder to idle, so a following target write programs nothing.
- R10: Erase takes six writes: 8'hAA@UNLOCK_A, 8'h55@UNLOCK_B, 8'h80@UNLOCK_A, 8'hAA@UNLOCK_A, 8'h55@UNLOCK_B, 8'h10@UNLOCK_A. Status reads follow for ERASE_CYCLES cycles, then every word reads 16'hFFFF.
- R11: bus_rdata is loaded on the clock edge that samples bus_rd high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data; the low byte carries command codes |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Array word or status word, one cycle after bus_rd |

## Verification
The bench holds the read strobe through a whole operation and compares every cycle with its own model. This pins down the last status cycle and the first data cycle: a timer that is off by one shows up as data one read early or as status one read late. Failing programs check that bit 5 and the frozen toggle appear on the same read and that bit 7 stays complemented. A design that raised the flags on different reads, or that let the toggle run on, would give the wrong word there. Writes sent during a running program (a reset byte and a full second program) must leave both words as the model predicts, which catches a decoder that listens while busy. Odd targets, broken unlock sequences and random subset or superset data check that nothing is programmed by accident and that 0 bits stay sticky.

// File: rtl/flashwr_pkg.sv
package flashwr_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_PGM_RUN,
        ST_ERS_RUN,
        ST_TIMEOUT
    } fw_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_RESET   = 8'hF0;

    localparam int FLAG_POLL = 7;
    localparam int FLAG_TGL  = 6;
    localparam int FLAG_TMO  = 5;

endpackage

// File: rtl/flashwr_timer.sv
module flashwr_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/flashwr_store.sv
module flashwr_store #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  look_idx,
    output logic [DATA_W-1:0] look_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic              pgm_we,
    input  logic [IDX_W-1:0]  pgm_idx,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              ers_all
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
        end else if (ers_all) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
        end else if (pgm_we) begin
            mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
        end
    end

    assign look_word = mem[look_idx];
    assign rd_word   = mem[rd_idx];

    // R4: a program commit never sets a bit that was clear
    p_clear_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_we && !ers_all |=> ((mem[$past(pgm_idx)] & ~$past(mem[pgm_idx])) == '0))
        else $error("program set a cleared bit");

endmodule

// File: rtl/flashwr_status.sv
module flashwr_status import flashwr_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic              tmo,
    input  logic              rd,
    input  logic              poll_bit,
    output logic [DATA_W-1:0] status_word
);

    logic toggle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else if (start) begin
            toggle_q <= 1'b0;
        end else if (rd && busy) begin
            toggle_q <= ~toggle_q;
        end
    end

    always_comb begin
        status_word            = '0;
        status_word[FLAG_POLL] = poll_bit;
        status_word[FLAG_TGL]  = toggle_q;
        status_word[FLAG_TMO]  = tmo;
    end

    // R6: each status read during a running operation inverts the toggle
    p_toggle_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd && !start |=> toggle_q != $past(toggle_q))
        else $error("toggle did not flip");

    // R7: toggle frozen while the timeout is shown
    p_toggle_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (!tmo || $stable(toggle_q)))
        else $error("toggle moved in timeout");

endmodule

// File: rtl/flashwr_cmd_fsm.sv
module flashwr_cmd_fsm import flashwr_pkg::*; #(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 16,
    parameter int                IDX_W    = 4,
    parameter logic [ADDR_W-1:0] UNLOCK_A = 12'hAAA,
    parameter logic [ADDR_W-1:0] UNLOCK_B = 12'h554
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] look_word,
    input  logic              tmr_zero,
    output fw_state_e         st,
    output logic              pgm_start,
    output logic              ers_start,
    output logic              pgm_commit,
    output logic              ers_commit,
    output logic              busy,
    output logic              tmo,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic [DATA_W-1:0] tgt_data
);

    fw_state_e st_nxt;
    logic      fail_q;
    logic [7:0] op;

    assign op = wdata[7:0];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] k,
                                 input logic [ADDR_W-1:0] ca, input logic [7:0] ck);
        return (a == ca) && (k == ck);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_READ;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_READ:    if (wr && hit(addr, op, UNLOCK_A, KEY_FIRST)) st_nxt = ST_UNL1;
            ST_UNL1:    if (wr) st_nxt = hit(addr, op, UNLOCK_B, KEY_SECOND) ? ST_UNL2 : ST_READ;
            ST_UNL2: begin
                if (wr) begin
                    if (hit(addr, op, UNLOCK_A, OP_PROGRAM))    st_nxt = ST_PGM_ARM;
                    else if (hit(addr, op, UNLOCK_A, OP_ERASE)) st_nxt = ST_ERS1;
                    else                                         st_nxt = ST_READ;
                end
            end
            ST_PGM_ARM: if (wr) st_nxt = addr[0] ? ST_READ : ST_PGM_RUN;
            ST_ERS1:    if (wr) st_nxt = hit(addr, op, UNLOCK_A, KEY_FIRST) ? ST_ERS2 : ST_READ;
            ST_ERS2:    if (wr) st_nxt = hit(addr, op, UNLOCK_B, KEY_SECOND) ? ST_ERS3 : ST_READ;
            ST_ERS3:    if (wr) st_nxt = hit(addr, op, UNLOCK_A, OP_CHIP) ? ST_ERS_RUN : ST_READ;
            ST_PGM_RUN: if (tmr_zero) st_nxt = fail_q ? ST_TIMEOUT : ST_READ;
            ST_ERS_RUN: if (tmr_zero) st_nxt = ST_READ;
            ST_TIMEOUT: if (wr && op == OP_RESET) st_nxt = ST_READ;
            default:    st_nxt = ST_READ;
        endcase
    end

    // outputs
    always_comb begin
        pgm_start  = (st == ST_PGM_ARM) && wr && !addr[0];
        ers_start  = (st == ST_ERS3) && wr && hit(addr, op, UNLOCK_A, OP_CHIP);
        pgm_commit = (st == ST_PGM_RUN) && tmr_zero;
        ers_commit = (st == ST_ERS_RUN) && tmr_zero;
        busy       = (st == ST_PGM_RUN) || (st == ST_ERS_RUN);
        tmo        = (st == ST_TIMEOUT);
    end

    // target capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_idx  <= '0;
            tgt_data <= '0;
            fail_q   <= 1'b0;
        end else if (pgm_start) begin
            tgt_idx  <= addr[IDX_W:1];
            tgt_data <= wdata;
            fail_q   <= |(~look_word & wdata);
        end else if (ers_start) begin
            tgt_data <= '1;
            fail_q   <= 1'b0;
        end
    end

    // R5: a running program stays running until its timer ends, whatever is written
    p_hold_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PGM_RUN) && !tmr_zero |=> st == ST_PGM_RUN)
        else $error("program left early");

    // R3: an odd target drops back to read mode
    p_odd_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PGM_ARM) && wr && addr[0] |=> st == ST_READ)
        else $error("odd target started a program");

    // R7: timeout can only follow a program run
    p_tmo_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TIMEOUT) && ($past(st) != ST_TIMEOUT) |-> $past(st) == ST_PGM_RUN)
        else $error("timeout entered from wrong state");

    // R8: only the reset byte leaves the timeout state
    p_tmo_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TIMEOUT) && !(wr && op == OP_RESET) |=> st == ST_TIMEOUT)
        else $error("timeout left without reset");

endmodule

// File: rtl/flashwr_engine.sv
module flashwr_engine import flashwr_pkg::*; #(
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 16,
    parameter int                WORDS        = 16,
    parameter int                PROG_CYCLES  = 12,
    parameter int                ERASE_CYCLES = 20,
    parameter logic [ADDR_W-1:0] UNLOCK_A     = 12'hAAA,
    parameter logic [ADDR_W-1:0] UNLOCK_B     = 12'h554
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int IDX_W  = $clog2(WORDS);
    localparam int MAXCYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W  = $clog2(MAXCYC + 1);

    fw_state_e         st;
    logic              pgm_start, ers_start, pgm_commit, ers_commit, busy, tmo, tmr_zero;
    logic [IDX_W-1:0]  tgt_idx;
    logic [DATA_W-1:0] tgt_data, look_word, rd_word, status_word;
    logic [CNT_W-1:0]  tmr_load;

    assign tmr_load = pgm_start ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1);

    flashwr_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .look_word(look_word), .tmr_zero(tmr_zero), .st(st),
        .pgm_start(pgm_start), .ers_start(ers_start),
        .pgm_commit(pgm_commit), .ers_commit(ers_commit),
        .busy(busy), .tmo(tmo), .tgt_idx(tgt_idx), .tgt_data(tgt_data)
    );

    flashwr_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(pgm_start | ers_start),
        .load(tmr_load), .zero(tmr_zero)
    );

    flashwr_store #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .look_idx(bus_addr[IDX_W:1]), .look_word(look_word),
        .rd_idx(bus_addr[IDX_W:1]), .rd_word(rd_word),
        .pgm_we(pgm_commit), .pgm_idx(tgt_idx), .pgm_data(tgt_data),
        .ers_all(ers_commit)
    );

    flashwr_status #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .start(pgm_start | ers_start),
        .busy(busy), .tmo(tmo), .rd(bus_rd), .poll_bit(~tgt_data[7]),
        .status_word(status_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= (busy || tmo) ? status_word : rd_word;
    end

    // R11: read data only changes on a sampled read
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata))
        else $error("read data moved without a read");

    // R6: a busy read never reports timeout
    p_busy_no_tmo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && busy |=> bus_rdata[FLAG_TMO] == 1'b0)
        else $error("timeout flag while busy");

endmodule

// File: tb/flashwr_engine_test.sv
`timescale 1ns/1ps
module flashwr_engine_test;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int WORDS  = 16;
    localparam int PCYC   = 12;
    localparam int ECYC   = 20;
    localparam logic [ADDR_W-1:0] UA = 12'hAAA;
    localparam logic [ADDR_W-1:0] UB = 12'h554;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DATA_W-1:0] model [WORDS];

    always #2.5 clk = ~clk;

    flashwr_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
        .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC), .UNLOCK_A(UA), .UNLOCK_B(UB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] exp_stat(input logic poll, input logic tgl, input logic tm);
        logic [15:0] s;
        s = '0;
        s[7] = poll;
        s[6] = tgl;
        s[5] = tm;
        return s;
    endfunction

    function automatic logic wants_set(input logic [15:0] old, input logic [15:0] d);
        return |(~old & d);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send_prog(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_write(UA, 16'h00AA);
        bus_write(UB, 16'h0055);
        bus_write(UA, 16'h00A0);
        bus_write(a, d);
    endtask

    // full program with a read held every cycle across the boundary
    task automatic run_prog(input int idx, input logic [15:0] d, input string req);
        logic [15:0] old, res;
        logic        bad;
        logic [ADDR_W-1:0] a;
        a   = ADDR_W'(idx * 2);
        old = model[idx];
        bad = wants_set(old, d);
        send_prog(a, d);
        bus_addr = a; bus_rd = 1'b1;
        for (int k = 1; k <= PCYC; k++) begin
            @(negedge clk);
            check({req, " R6 busy status"}, bus_rdata, exp_stat(~d[7], 1'((k - 1) % 2), 1'b0));
        end
        @(negedge clk);
        if (!bad) begin
            check({req, " R2 data after program"}, bus_rdata, old & d);
        end else begin
            check({req, " R7 timeout status"}, bus_rdata, exp_stat(~d[7], 1'(PCYC % 2), 1'b1));
            @(negedge clk);
            check({req, " R7 toggle frozen"}, bus_rdata, exp_stat(~d[7], 1'(PCYC % 2), 1'b1));
        end
        bus_rd = 1'b0;
        model[idx] = old & d;
        if (bad) begin
            bus_write(UA, 16'h00AA);
            bus_read(a, res);
            check({req, " R8 non-reset write keeps timeout"}, res, exp_stat(~d[7], 1'(PCYC % 2), 1'b1));
            bus_write(a, 16'h00F0);
        end
        bus_read(a, res);
        check({req, " R4 stored AND"}, res, model[idx]);
    endtask

    task automatic run_erase();
        logic [15:0] res;
        bus_write(UA, 16'h00AA);
        bus_write(UB, 16'h0055);
        bus_write(UA, 16'h0080);
        bus_write(UA, 16'h00AA);
        bus_write(UB, 16'h0055);
        bus_write(UA, 16'h0010);
        bus_addr = '0; bus_rd = 1'b1;
        for (int k = 1; k <= ECYC; k++) begin
            @(negedge clk);
            check("R10 erase status", bus_rdata, exp_stat(1'b0, 1'((k - 1) % 2), 1'b0));
        end
        bus_rd = 1'b0;
        for (int w = 0; w < WORDS; w++) model[w] = '1;
        for (int w = 0; w < WORDS; w += 5) begin
            bus_read(ADDR_W'(w * 2), res);
            check("R10 erased word", res, 16'hFFFF);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] res, held;
        void'($urandom(32'h1F2E3D4C));
        for (int w = 0; w < WORDS; w++) model[w] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int w = 0; w < WORDS; w += 3) begin
            bus_read(ADDR_W'(w * 2), res);
            check("R1 erased after reset", res, 16'hFFFF);
        end

        // R11 output holds without a read
        held = bus_rdata;
        repeat (3) @(negedge clk);
        check("R11 rdata hold", bus_rdata, held);

        // R2 directed success, R7/R8 directed failure
        run_prog(3, 16'h1234, "directed ok");
        run_prog(3, 16'h00FF, "directed fail");
        run_prog(4, 16'hFF7F, "bit7 clear");

        // R3 odd target
        bus_write(UA, 16'h00AA);
        bus_write(UB, 16'h0055);
        bus_write(UA, 16'h00A0);
        bus_write(ADDR_W'(5 * 2 + 1), 16'h0000);
        bus_read(ADDR_W'(5 * 2), res);
        check("R3 odd target ignored", res, model[5]);

        // R9 broken unlock
        bus_write(UA, 16'h00AA);
        bus_write(UA, 16'h0055);
        bus_write(UA, 16'h00A0);
        bus_write(ADDR_W'(6 * 2), 16'h0000);
        bus_read(ADDR_W'(6 * 2), res);
        check("R9 broken sequence no program", res, model[6]);

        // R5 writes ignored while busy
        send_prog(ADDR_W'(7 * 2), 16'h0F0F);
        bus_write(UA, 16'h00F0);
        send_prog(ADDR_W'(8 * 2), 16'h0000);
        repeat (PCYC) @(negedge clk);
        model[7] = model[7] & 16'h0F0F;
        bus_read(ADDR_W'(7 * 2), res);
        check("R5 target programmed despite writes", res, model[7]);
        bus_read(ADDR_W'(8 * 2), res);
        check("R5 busy-time program ignored", res, model[8]);

        // R10 erase
        run_erase();

        // random mix
        for (int it = 0; it < 30; it++) begin
            int idx;
            int sel;
            logic [15:0] d;
            idx = int'($urandom % WORDS);
            sel = int'($urandom % 8);
            d   = 16'($urandom);
            if (sel == 0) begin
                bus_write(UA, 16'h00AA);
                bus_write(UB, 16'h0055);
                bus_write(UA, 16'h00A0);
                bus_write(ADDR_W'(idx * 2 + 1), d);
                bus_read(ADDR_W'(idx * 2), res);
                check("R3 random odd", res, model[idx]);
            end else if (sel == 1 && it > 20) begin
                run_erase();
            end else if (sel < 5) begin
                run_prog(idx, model[idx] & d, "random subset");
            end else begin
                run_prog(idx, d, "random any");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule